// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple synchronous request port to an asynchronous dynamic RAM that shares nine address pins between the row and the column half of each access. The strobes are active low: row strobe, column strobe and write enable. The host offers an 18-bit word address with a read or write flag under a valid/ready handshake. The controller then steps through the strobe sequence. Every interval is a parameter counted in clock cycles. Read data comes back on a one-cycle valid pulse.

After an access the row is left open. A later request to the same row is served by cycling only the column strobe, which saves the row-strobe overhead. A request to another row closes the page first. A page is also closed before the row strobe could stay low longer than its limit. A free-running interval timer requests refresh. Refresh runs as a row-strobe-only cycle on the next entry of an 8-bit row counter and always wins over new host requests.

Top module: `dramc_top`

## Requirements
- R1: A host address A is split as row = A[17:9] and column = A[8:0]. The row is on `dram_addr` when `dram_ras_n` falls and the column is on it when `dram_cas_n` falls, so data written at A is read back at A.
- R2: The row address is on the pins one cycle before `dram_ras_n` falls and stays unchanged for the first T_RAH cycles of row strobe low. For a fresh row, `dram_cas_n` falls exactly T_RCD cycles after `dram_ras_n` falls.
- R3: For a write, `dram_we_n` is low at least one cycle before `dram_cas_n` falls (early write) and `dram_din` holds the write data. For a read, `dram_we_n` is high when `dram_cas_n` falls.
- R4: Each read produces `host_rvalid` high for exactly one cycle. `host_rdata` holds `dram_dout` sampled at the end of the T_RD-th cycle of column strobe low, so the pulse shows T_RD cycles after the column strobe falls.
- R5: While a row is open, a request to the same row is accepted without a new falling edge of `dram_ras_n`. A request to a different row causes a new row-strobe cycle.
- R6: Refresh is a cycle with `dram_ras_n` low for at least T_RAS cycles and `dram_cas_n` high throughout. The pins carry {1'b0, counter[7:0]}. The counter starts at 0 after reset, advances by one per refresh and wraps from 255 to 0. The column strobe is never low while the row strobe is high.
- R7: Refresh takes priority over host requests. The start of each refresh comes no more than REF_INTERVAL + 24 cycles after the start of the previous one (after reset, for the first).
- R8: `dram_ras_n` never stays low for more than T_RAS_MAX cycles. Every low period is preceded by at least T_RP high cycles.
- R9: While and right after reset, all three strobes are high, `host_rvalid` is low and `host_ready` is high.
- R10: A request is taken only in a cycle with `host_valid` and `host_ready` both high. Each accepted read yields exactly one `host_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Request taken this cycle if valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | One-cycle read data strobe |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | DATA_W | Data to the memory |
| dram_dout | input | DATA_W | Data from the memory |

## Verification
The assertions assume that the host keeps `host_valid`, `host_we`, `host_addr` and `host_wdata` steady from the moment it raises valid until the accepting edge. They also assume that the timing parameters obey T_RAH < T_RCD, 1 <= T_RD <= T_CAS and T_RCD + T_CAS + T_CP + 1 < T_RAS_MAX. The bench changes its request fields only at falling clock edges, holds them until acceptance, and uses the default timing set, which meets these limits. A memory model in the bench reacts to the strobes and stores written words. Random traffic is confined to a few rows so that page hits, page misses and closes forced by the row-strobe limit all occur mixed with refresh.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    localparam int ADDR_W    = 18;
    localparam int PIN_W     = 9;
    localparam int REF_ROW_W = 8;

    typedef logic [PIN_W-1:0]  pin_addr_t;
    typedef logic [ADDR_W-1:0] host_addr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RSET,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_CPRE,
        ST_OPEN,
        ST_PRE,
        ST_FSET,
        ST_FRAS
    } seq_state_e;

    typedef struct packed {
        logic      we;
        pin_addr_t row;
        pin_addr_t col;
    } req_hdr_t;

    function automatic pin_addr_t row_of(input host_addr_t a);
        return a[ADDR_W-1:PIN_W];
    endfunction

    function automatic pin_addr_t col_of(input host_addr_t a);
        return a[PIN_W-1:0];
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dramc_refresh_sched.sv
module dramc_refresh_sched
    import dramc_pkg::*;
#(
    parameter int REF_INTERVAL = 3000,
    parameter int ROW_W        = REF_ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);

    localparam int TW = $clog2(REF_INTERVAL + 1);

    logic [TW-1:0] tick_cnt;
    logic          tick_wrap;

    assign tick_wrap = (tick_cnt == TW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            if (ref_done) begin
                ref_pend <= 1'b0;
                ref_row  <= ref_row + 1'b1;
            end
            if (tick_wrap) begin
                tick_cnt <= '0;
                ref_pend <= 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // A new tick must never find the previous refresh still waiting.
    assert_no_missed_refresh_R7: assert property (@(posedge clk) disable iff (rst)
        tick_wrap |-> (!ref_pend || ref_done));

endmodule

// File: rtl/dramc_open_row.sv
module dramc_open_row
    import dramc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      open_set,
    input  logic      open_clr,
    input  pin_addr_t set_row,
    input  pin_addr_t probe_row,
    output logic      hit
);

    pin_addr_t open_row;
    logic      open_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (open_clr) begin
            open_vld <= 1'b0;
        end else if (open_set) begin
            open_vld <= 1'b1;
            open_row <= set_row;
        end
    end

    assign hit = open_vld && (probe_row == open_row);

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int DATA_W    = 4,
    parameter int T_RCD     = 3,
    parameter int T_RAH     = 1,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RAS_MAX = 40,
    parameter int T_RD      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_valid,
    output logic                 host_ready,
    input  logic                 host_we,
    input  host_addr_t           host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    input  logic                 hit,
    output logic                 open_set,
    output logic                 open_clr,
    output pin_addr_t            cur_row,
    input  logic                 ref_pend,
    input  logic [REF_ROW_W-1:0] ref_row,
    output logic                 ref_done,
    output pin_addr_t            dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic [DATA_W-1:0]    dram_din,
    input  logic [DATA_W-1:0]    dram_dout
);

    localparam int CNT_MAX   = max_of(max_of(T_RCD, T_CAS), max_of(max_of(T_CP, T_RP), T_RAS));
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int RUN_W     = $clog2(T_RAS_MAX + 1) + 1;
    localparam int HIT_LIMIT = T_RAS_MAX - T_CAS - T_CP - 3;

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [RUN_W-1:0]  ras_run;
    req_hdr_t          req;
    logic [DATA_W-1:0] wdata_q;

    logic ras_low, accept, may_close, hit_room, close_now, col_phase;

    assign ras_low = (state == ST_ROW) || (state == ST_COL) || (state == ST_CAS) ||
                     (state == ST_CPRE) || (state == ST_OPEN) || (state == ST_FRAS);

    assign hit_room  = (ras_run <= RUN_W'(HIT_LIMIT));
    assign may_close = (ras_run >= RUN_W'(T_RAS - 1));
    assign close_now = (state == ST_OPEN) && may_close &&
                       (ref_pend || !hit_room || (host_valid && !hit));

    always_comb begin
        host_ready = 1'b0;
        if (state == ST_IDLE)
            host_ready = !ref_pend;
        else if (state == ST_OPEN)
            host_ready = hit && !ref_pend && hit_room;
    end

    assign accept   = host_valid && host_ready;
    assign open_set = (state == ST_RSET);
    assign open_clr = close_now;
    assign cur_row  = req.row;
    assign ref_done = (state == ST_FRAS) && (cnt == CNT_W'(T_RAS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            ras_run     <= '0;
            req         <= '0;
            wdata_q     <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            ras_run     <= ras_low ? ras_run + 1'b1 : '0;
            host_rvalid <= (state == ST_CAS) && (cnt == CNT_W'(T_RD - 1)) && !req.we;
            if ((state == ST_CAS) && (cnt == CNT_W'(T_RD - 1)))
                host_rdata <= dram_dout;
            if (accept) begin
                req.we  <= host_we;
                req.row <= row_of(host_addr);
                req.col <= col_of(host_addr);
                wdata_q <= host_wdata;
            end
            cnt <= cnt + 1'b1;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ref_pend)    state <= ST_FSET;
                    else if (accept) state <= ST_RSET;
                end
                ST_RSET: begin
                    cnt   <= '0;
                    state <= ST_ROW;
                end
                ST_ROW: if (cnt == CNT_W'(T_RCD - 1)) begin
                    cnt   <= '0;
                    state <= ST_CAS;
                end
                ST_COL: begin
                    cnt   <= '0;
                    state <= ST_CAS;
                end
                ST_CAS: if (cnt == CNT_W'(T_CAS - 1)) begin
                    cnt   <= '0;
                    state <= ST_CPRE;
                end
                ST_CPRE: if (cnt == CNT_W'(T_CP - 1)) begin
                    cnt   <= '0;
                    state <= ST_OPEN;
                end
                ST_OPEN: begin
                    cnt <= '0;
                    if (close_now)   state <= ST_PRE;
                    else if (accept) state <= ST_COL;
                end
                ST_PRE: if (cnt == CNT_W'(T_RP - 1)) begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end
                ST_FSET: begin
                    cnt   <= '0;
                    state <= ST_FRAS;
                end
                ST_FRAS: if (cnt == CNT_W'(T_RAS - 1)) begin
                    cnt   <= '0;
                    state <= ST_PRE;
                end
                default: begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign col_phase = ((state == ST_ROW) && (cnt >= CNT_W'(T_RAH))) ||
                       (state == ST_COL) || (state == ST_CAS);

    always_comb begin
        dram_addr = req.col;
        if ((state == ST_RSET) || ((state == ST_ROW) && (cnt < CNT_W'(T_RAH))))
            dram_addr = req.row;
        else if ((state == ST_FSET) || (state == ST_FRAS))
            dram_addr = {{(PIN_W-REF_ROW_W){1'b0}}, ref_row};
    end

    assign dram_ras_n = !ras_low;
    assign dram_cas_n = (state != ST_CAS);
    assign dram_we_n  = !(req.we && col_phase);
    assign dram_din   = wdata_q;

    assert_row_setup_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> $stable(dram_addr));

    assert_early_write_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));

    assert_cas_inside_ras_R6: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    assert_refresh_first_R7: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !accept);

endmodule

// File: rtl/dramc_top.sv
module dramc_top
    import dramc_pkg::*;
#(
    parameter int DATA_W       = 4,
    parameter int T_RCD        = 3,
    parameter int T_RAH        = 1,
    parameter int T_CAS        = 3,
    parameter int T_CP         = 2,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 6,
    parameter int T_RAS_MAX    = 40,
    parameter int T_RD         = 2,
    parameter int REF_INTERVAL = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_we,
    input  logic [17:0]       host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [8:0]        dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_din,
    input  logic [DATA_W-1:0] dram_dout
);

    localparam int RUN_W = $clog2(T_RAS_MAX + 1) + 1;

    logic                 hit, open_set, open_clr, ref_pend, ref_done;
    pin_addr_t            cur_row;
    logic [REF_ROW_W-1:0] ref_row;

    dramc_refresh_sched #(
        .REF_INTERVAL(REF_INTERVAL),
        .ROW_W       (REF_ROW_W)
    ) u_ref (
        .clk     (clk),
        .rst     (rst),
        .ref_done(ref_done),
        .ref_pend(ref_pend),
        .ref_row (ref_row)
    );

    dramc_open_row u_page (
        .clk      (clk),
        .rst      (rst),
        .open_set (open_set),
        .open_clr (open_clr),
        .set_row  (cur_row),
        .probe_row(row_of(host_addr)),
        .hit      (hit)
    );

    dramc_seq #(
        .DATA_W   (DATA_W),
        .T_RCD    (T_RCD),
        .T_RAH    (T_RAH),
        .T_CAS    (T_CAS),
        .T_CP     (T_CP),
        .T_RP     (T_RP),
        .T_RAS    (T_RAS),
        .T_RAS_MAX(T_RAS_MAX),
        .T_RD     (T_RD)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .hit        (hit),
        .open_set   (open_set),
        .open_clr   (open_clr),
        .cur_row    (cur_row),
        .ref_pend   (ref_pend),
        .ref_row    (ref_row),
        .ref_done   (ref_done),
        .dram_addr  (dram_addr),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_din   (dram_din),
        .dram_dout  (dram_dout)
    );

    // Independent watch on the row strobe low time.
    logic [RUN_W-1:0] ras_low_seen;

    always_ff @(posedge clk) begin
        if (rst)             ras_low_seen <= '0;
        else if (dram_ras_n) ras_low_seen <= '0;
        else                 ras_low_seen <= ras_low_seen + 1'b1;
    end

    assert_ras_max_R8: assert property (@(posedge clk) disable iff (rst)
        !dram_ras_n |-> (ras_low_seen < RUN_W'(T_RAS_MAX)));

endmodule

// File: tb/dramc_top_bench.sv
`timescale 1ns/100ps
module dramc_top_bench;

    localparam int DW        = 4;
    localparam int REF_INT   = 200;
    localparam int T_RCD     = 3;
    localparam int T_RAH     = 1;
    localparam int T_CAS     = 3;
    localparam int T_CP      = 2;
    localparam int T_RP      = 3;
    localparam int T_RAS     = 6;
    localparam int T_RAS_MAX = 40;
    localparam int T_RD      = 2;
    localparam int SLACK     = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_valid = 1'b0;
    logic          host_we = 1'b0;
    logic [17:0]   host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [8:0]    dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n;
    logic [DW-1:0] dram_din;
    logic [DW-1:0] dout_m = '0;

    dramc_top #(
        .DATA_W(DW), .T_RCD(T_RCD), .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RP(T_RP), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX), .T_RD(T_RD),
        .REF_INTERVAL(REF_INT)
    ) u_dramc_top (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_din(dram_din), .dram_dout(dout_m)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input logic [17:0] k);
        return k[DW-1:0] ^ k[DW+4:5] ^ 4'h9;
    endfunction

    // Memory model and strobe observer
    logic [DW-1:0] mmem [logic [17:0]];
    logic [DW-1:0] ref_mem [logic [17:0]];
    logic [DW-1:0] exp_q [$];

    int   cyc = 0, fall_cyc = 0, last_ref_fall = 0, rd_cas_cyc = 0;
    int   low_run = 0, high_run = 100, t_fall = 0;
    int   ras_falls = 0, ref_count = 0, rv_count = 0, reads_issued = 0;
    bit   prev_ras = 1, prev_cas = 1, prev_we = 1, prev_rv = 0, cas_seen = 0, saw_wrap = 0;
    logic [8:0] prev_addr = '0, cur_row = '0;
    logic [7:0] exp_ref = '0;

    always @(negedge clk) begin
        if (rst) begin
            last_ref_fall = cyc;
        end else begin
            logic [17:0]   key;
            logic [DW-1:0] e;
            cyc++;
            if (!dram_ras_n && prev_ras) begin
                check(dram_addr == prev_addr, "R2", "row address setup", dram_addr, prev_addr);
                check(high_run >= T_RP, "R8", "precharge length", high_run, T_RP);
                cur_row = dram_addr; t_fall = 0; cas_seen = 0; fall_cyc = cyc;
                ras_falls++; low_run = 0;
            end
            if (!dram_ras_n) begin
                low_run++;
                if (!cas_seen && t_fall < T_RAH)
                    check(dram_addr == cur_row, "R2", "row hold", dram_addr, cur_row);
                t_fall++;
            end
            if (!dram_cas_n && prev_cas) begin
                check(!dram_ras_n, "R6", "column strobe inside row strobe", dram_ras_n, 0);
                if (!cas_seen)
                    check(cyc - fall_cyc == T_RCD, "R2", "row to column delay", cyc - fall_cyc, T_RCD);
                cas_seen = 1;
                key = {cur_row, dram_addr};
                if (!dram_we_n) begin
                    check(!prev_we, "R3", "write enable before column strobe", prev_we, 0);
                    mmem[key] = dram_din;
                end else begin
                    dout_m = mmem.exists(key) ? mmem[key] : pattern(key);
                    rd_cas_cyc = cyc;
                end
            end
            if (dram_ras_n && !prev_ras) begin
                check(low_run <= T_RAS_MAX, "R8", "row strobe low width", low_run, T_RAS_MAX);
                if (!cas_seen) begin
                    check(cur_row == {1'b0, exp_ref}, "R6", "refresh row", cur_row, exp_ref);
                    check(low_run >= T_RAS, "R6", "refresh low width", low_run, T_RAS);
                    check(fall_cyc - last_ref_fall <= REF_INT + SLACK, "R7", "refresh spacing",
                          fall_cyc - last_ref_fall, REF_INT + SLACK);
                    last_ref_fall = fall_cyc;
                    exp_ref = exp_ref + 8'd1;
                    if (exp_ref == 8'd0) saw_wrap = 1;
                    ref_count++;
                end
                high_run = 0;
            end
            if (dram_ras_n) high_run++;
            if (host_rvalid) begin
                check(!prev_rv, "R4", "read strobe one cycle", prev_rv, 0);
                check(cyc - rd_cas_cyc == T_RD, "R4", "read latency", cyc - rd_cas_cyc, T_RD);
                if (exp_q.size() == 0) begin
                    check(0, "R10", "read strobe without read", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(host_rdata == e, "R1", "read data", host_rdata, e);
                end
                rv_count++;
            end
            prev_rv = host_rvalid;
        end
        prev_ras  = dram_ras_n;
        prev_cas  = dram_cas_n;
        prev_we   = dram_we_n;
        prev_addr = dram_addr;
    end

    task automatic issue(input bit we, input logic [17:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        if (we) begin
            ref_mem[a] = d;
        end else begin
            exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : pattern(a));
            reads_issued++;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic after_refresh();
        int rc;
        rc = ref_count;
        while (ref_count == rc) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int f0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset values
        check(dram_ras_n && dram_cas_n && dram_we_n, "R9", "strobes high in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!host_rvalid, "R9", "no read strobe in reset", host_rvalid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(host_ready, "R9", "ready after reset", host_ready, 1);

        // R1: corner addresses
        issue(1, 18'h00000, 4'h5);
        issue(1, 18'h3FFFF, 4'hA);
        issue(0, 18'h00000, 4'h0);
        issue(0, 18'h3FFFF, 4'h0);
        issue(0, 18'h12345, 4'h0);
        drain();

        // R5: hits on one row keep the row strobe low
        after_refresh();
        f0 = ras_falls;
        issue(1, {9'h0A5, 9'h003}, 4'h3);
        issue(0, {9'h0A5, 9'h004}, 4'h0);
        issue(1, {9'h0A5, 9'h005}, 4'hC);
        issue(0, {9'h0A5, 9'h003}, 4'h0);
        drain();
        check(ras_falls - f0 == 1, "R5", "row strobe falls on page hits", ras_falls - f0, 1);

        // R5: a different row reopens
        after_refresh();
        f0 = ras_falls;
        issue(1, {9'h0A5, 9'h010}, 4'h6);
        issue(0, {9'h0A6, 9'h010}, 4'h0);
        drain();
        check(ras_falls - f0 == 2, "R5", "row strobe falls on page miss", ras_falls - f0, 2);

        // R8: a long hit stream is split by the low-time limit
        after_refresh();
        f0 = ras_falls;
        for (int i = 0; i < 12; i++) issue(i[0], {9'h155, 9'(i)}, 4'(i));
        drain();
        check(ras_falls - f0 >= 2, "R8", "page closed by low-time limit", ras_falls - f0, 2);

        // Random traffic over a few rows
        for (int i = 0; i < 2500; i++) begin
            logic [8:0] r;
            case ($urandom % 4)
                0: r = 9'h000;
                1: r = 9'h1FF;
                2: r = 9'h155;
                default: r = 9'($urandom);
            endcase
            issue(($urandom % 2) == 1, {r, 9'($urandom % 16)}, 4'($urandom));
            repeat ($urandom % 4) @(negedge clk);
        end
        drain();

        // R6: counter wraps after 256 refreshes
        while (ref_count < 258) @(negedge clk);
        check(saw_wrap, "R6", "refresh counter wrapped", saw_wrap, 1);
        check(ref_count >= 258, "R7", "refreshes kept running", ref_count, 258);
        // R10: one read strobe per read
        check(rv_count == reads_issued, "R10", "read strobes per read", rv_count, reads_issued);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule